// File: doc/BRIEF.md
# One-Bit Function-Select ALU Slice

This block is a purely combinational arithmetic and logic slice that works on single data bits. It has two operand bits, a carry/borrow input and a three-bit operation code. It returns a result bit and a carry/borrow output. The code selects one of eight operations: a clear, three pass operations, two bitwise logic operations, a full add and a full subtract. Several of the pass and logic operations also drive the carry output with a fixed value or with the first operand. The carry output is never left unused.

The add and the subtract are each built in their own sub-unit, and both sub-units compute in parallel. A decode stage picks the result pair from the unit, logic term or constant that the code names. The slice holds no state, so its outputs follow its inputs within the same cycle. A wider datapath places the slice next to others of its kind and joins each carry output to the next carry input.

Top module: `fsel_alu_bit`

## Requirements
- R1: Code 3'b000 (clear) drives res=0 and c_out=0 whatever the operands are.
- R2: Code 3'b001 (pass A) drives res=a_bit and c_out=0.
- R3: Code 3'b010 (pass B) drives res=b_bit and c_out=1.
- R4: Code 3'b011 (pass carry) drives res=c_in and c_out=a_bit.
- R5: Code 3'b100 (OR) drives res=a_bit|b_bit and c_out=a_bit.
- R6: Code 3'b101 (AND) drives res=a_bit&b_bit and c_out=a_bit.
- R7: Code 3'b110 (add) drives {c_out,res} with the two-bit sum a_bit+b_bit+c_in.
- R8: Code 3'b111 (subtract) computes a_bit-b_bit-c_in. It drives res with the difference bit a_bit^b_bit^c_in. It drives c_out=1 exactly when that difference is negative (a borrow).
- R9: Outputs are a function of the present inputs alone. When the inputs change, the outputs take their new values with no clock edge in between, and they depend on no earlier input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_bit | input | 1 | First operand bit |
| b_bit | input | 1 | Second operand bit |
| c_in | input | 1 | Carry-in for add, borrow-in for subtract, data for pass carry |
| op | input | 3 | Operation code |
| res | output | 1 | Result bit |
| c_out | output | 1 | Carry or borrow out, or the fixed value the code assigns |

## Verification
All 64 combinations of the operands, the carry input and the code are applied, first in ascending order and then in descending order. The ascending sweep separates the operations from one another: for each code, every operand pattern has to give the result and the carry output the reference expects. The two sub-units are told apart by the cases where add and subtract share a result bit but differ in carry, such as a=0, b=1, c_in=0. The descending sweep applies every pattern after a different predecessor than before, so a stale or stored value would show as a mismatch.

// File: rtl/fsel_alu_pkg.sv
package fsel_alu_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_CLEAR  = 3'b000,
        OP_PASS_A = 3'b001,
        OP_PASS_B = 3'b010,
        OP_PASS_C = 3'b011,
        OP_OR     = 3'b100,
        OP_AND    = 3'b101,
        OP_ADD    = 3'b110,
        OP_SUB    = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic carry;
        logic value;
    } bit_pair_t;

endpackage

// File: rtl/fsel_bit_adder.sv
module fsel_bit_adder
    import fsel_alu_pkg::*;
(
    input  logic      a_in,
    input  logic      b_in,
    input  logic      ci,
    output bit_pair_t sum_o
);
    logic half_x;

    always_comb begin
        half_x      = a_in ^ b_in;
        sum_o.value = half_x ^ ci;
        sum_o.carry = (a_in & b_in) | (half_x & ci);
    end

    // R7: pair equals arithmetic sum
    always_comb begin
        if (!$isunknown({a_in, b_in, ci}))
            a_r7_adder_sum: assert ({sum_o.carry, sum_o.value} ==
                                    2'(a_in) + 2'(b_in) + 2'(ci))
                else $error("adder pair mismatch");
    end
endmodule

// File: rtl/fsel_bit_subtractor.sv
module fsel_bit_subtractor
    import fsel_alu_pkg::*;
(
    input  logic      a_in,
    input  logic      b_in,
    input  logic      bi,
    output bit_pair_t diff_o
);
    logic half_x;

    always_comb begin
        half_x       = a_in ^ b_in;
        diff_o.value = half_x ^ bi;
        diff_o.carry = (~a_in & b_in) | (~half_x & bi);
    end

    // R8: a - b - bi == value - 2*borrow
    always_comb begin
        if (!$isunknown({a_in, b_in, bi}))
            a_r8_sub_borrow: assert (int'(a_in) - int'(b_in) - int'(bi) ==
                                     int'(diff_o.value) - 2 * int'(diff_o.carry))
                else $error("subtractor pair mismatch");
    end
endmodule

// File: rtl/fsel_op_decode.sv
module fsel_op_decode
    import fsel_alu_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic            a_in,
    input  logic            b_in,
    input  logic            ci,
    input  bit_pair_t       add_i,
    input  bit_pair_t       sub_i,
    output bit_pair_t       out_o
);
    alu_op_e op_e;

    always_comb begin
        op_e = alu_op_e'(op_i);
        out_o = '0;
        unique case (op_e)
            OP_CLEAR:  out_o = '{carry: 1'b0, value: 1'b0};
            OP_PASS_A: out_o = '{carry: 1'b0, value: a_in};
            OP_PASS_B: out_o = '{carry: 1'b1, value: b_in};
            OP_PASS_C: out_o = '{carry: a_in, value: ci};
            OP_OR:     out_o = '{carry: a_in, value: a_in | b_in};
            OP_AND:    out_o = '{carry: a_in, value: a_in & b_in};
            OP_ADD:    out_o = add_i;
            OP_SUB:    out_o = sub_i;
            default:   out_o = '0;
        endcase
    end

    // R1 / R3: fixed carry codes
    always_comb begin
        if (!$isunknown(op_i)) begin
            if (op_i == 3'b000)
                a_r1_clear_zero: assert (out_o == '0)
                    else $error("clear not zero");
            if (op_i == 3'b010)
                a_r3_pass_b_carry: assert (out_o.carry == 1'b1)
                    else $error("pass B carry not one");
            if (op_i == 3'b011 && !$isunknown(a_in))
                a_r4_pass_c_carry: assert (out_o.carry == a_in)
                    else $error("pass carry code carry mismatch");
        end
    end
endmodule

// File: rtl/fsel_alu_bit.sv
module fsel_alu_bit
    import fsel_alu_pkg::*;
(
    input  logic            a_bit,
    input  logic            b_bit,
    input  logic            c_in,
    input  logic [OP_W-1:0] op,
    output logic            res,
    output logic            c_out
);
    bit_pair_t add_w;
    bit_pair_t sub_w;
    bit_pair_t sel_w;

    fsel_bit_adder u_add (
        .a_in  (a_bit),
        .b_in  (b_bit),
        .ci    (c_in),
        .sum_o (add_w)
    );

    fsel_bit_subtractor u_sub (
        .a_in   (a_bit),
        .b_in   (b_bit),
        .bi     (c_in),
        .diff_o (sub_w)
    );

    fsel_op_decode u_dec (
        .op_i  (op),
        .a_in  (a_bit),
        .b_in  (b_bit),
        .ci    (c_in),
        .add_i (add_w),
        .sub_i (sub_w),
        .out_o (sel_w)
    );

    assign res   = sel_w.value;
    assign c_out = sel_w.carry;

    // R5 / R6 / R7 at the ports
    always_comb begin
        if (!$isunknown({op, a_bit, b_bit, c_in})) begin
            if (op == 3'b100)
                a_r5_or_ports: assert (res == (a_bit | b_bit) && c_out == a_bit)
                    else $error("OR code mismatch");
            if (op == 3'b101)
                a_r6_and_ports: assert (res == (a_bit & b_bit) && c_out == a_bit)
                    else $error("AND code mismatch");
            if (op == 3'b110)
                a_r7_add_ports: assert ({c_out, res} == 2'(a_bit) + 2'(b_bit) + 2'(c_in))
                    else $error("add code mismatch");
        end
    end
endmodule

// File: tb/fsel_alu_bit_bench.sv
module fsel_alu_bit_bench;

    logic       clk = 1'b0;
    logic       a_bit, b_bit, c_in;
    logic [2:0] op;
    logic       res, c_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fsel_alu_bit u_fsel_alu_bit (
        .a_bit (a_bit),
        .b_bit (b_bit),
        .c_in  (c_in),
        .op    (op),
        .res   (res),
        .c_out (c_out)
    );

    function automatic string req_of(int code);
        case (code)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic expect_pair(int code, int a, int b, int c, output int er, output int ec);
        int t;
        case (code)
            0: begin er = 0; ec = 0; end
            1: begin er = a; ec = 0; end
            2: begin er = b; ec = 1; end
            3: begin er = c; ec = a; end
            4: begin er = (a + b > 0) ? 1 : 0; ec = a; end
            5: begin er = (a + b == 2) ? 1 : 0; ec = a; end
            6: begin t = a + b + c; er = t % 2; ec = t / 2; end
            default: begin t = a - b - c; ec = (t < 0) ? 1 : 0; er = t + 2 * ec; end
        endcase
    endtask

    task automatic check(string tag, int act, int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d (a=%0b b=%0b c=%0b op=%0d)",
                     tag, act, exp_v, a_bit, b_bit, c_in, op);
        end
    endtask

    task automatic apply(int idx);
        int er, ec;
        int code = idx / 8;
        int a = (idx >> 2) & 1;
        int b = (idx >> 1) & 1;
        int c = idx & 1;
        @(posedge clk);
        #1;
        op = 3'(code); a_bit = a[0]; b_bit = b[0]; c_in = c[0];
        @(negedge clk);
        expect_pair(code, a, b, c, er, ec);
        check({req_of(code), " res"}, int'(res), er);
        check({req_of(code), " c_out"}, int'(c_out), ec);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        op = 3'b000; a_bit = 1'b1; b_bit = 1'b1; c_in = 1'b1;
        @(negedge clk);
        // R1: initial state with clear code and all operands high
        check("R1 init res", int'(res), 0);
        check("R1 init c_out", int'(c_out), 0);
        // R9: ascending then descending; same expected value regardless of history
        for (int i = 0; i < 64; i++) apply(i);
        for (int i = 63; i >= 0; i--) apply(i);
        // R9: input change settles without a clock edge
        @(negedge clk);
        op = 3'b001; a_bit = 1'b0; #0.5;
        a_bit = 1'b1; #0.5;
        check("R9 comb res", int'(res), 1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule